// File: doc/BRIEF.md
# Shared Segment/GPIO Pin Mux

This block sits between a bank of shared pads and two users of those pads: the LCD controller and software-controlled general-purpose I/O. For each pad, a mode bit decides whether the pad carries a segment drive level or acts as a digital pin. A digital pin has its own direction bit and output data bit. All three registers are reached through a small register bus. Pad input levels pass through a two-stage synchronizer. Software reads them back through the same bus.

A fixed window of ten adjacent pads, plus one separate input-only pad, is also tapped to feed internal interrupt and timer-start logic. The tap follows the synchronized pad level whatever the direction or mode of the pad. A pad driven as an output can therefore still raise an event. The LCD multiplex depth overrides everything else on two pads. With five or more commons, one pad becomes a common line. With six commons, a second pad does as well. The software settings for those pads are kept, and they take effect again once the depth is lowered.

Top module: `shared_pin_mux`

## Requirements
- R1: After reset, the mode, direction and data registers are all zero. Every pad has pad_oe=0 and pad_seg_en=0, so every pad is a digital input.
- R2: A pad whose mode bit is 1 (and is not claimed as a common) has pad_seg_en=1 and pad_oe=0, and carries its seg_lvl code on pad_lvl. A pad in I/O mode shows pad_lvl=0.
- R3: An unclaimed I/O-mode pad whose direction bit is 1 has pad_oe=1 and pad_do equal to its data bit. With direction 0, pad_oe=0 and pad_do=0. Each pad is independent of the others.
- R4: Register bus map. Address 0 is the mode map (1 = segment). Address 1 is direction (1 = output). Address 2 is output data. A write takes effect at the clock edge where bus_wr=1. Reads at addresses 0 and 1 return the stored value. Address 3 reads as zero and ignores writes.
- R5: A read at address 2 returns a per-pad view. An I/O output pad returns its data bit. An I/O input pad returns its pad_di level as it stood two clock edges earlier. A segment or claimed pad returns 0.
- R6: evt_out bit k (k=0..9) is pad_di of pad k+2, and evt_out bit 10 is btn_di. Each bit has a latency of exactly two clock edges.
- R7: evt_out does not depend on the mode or direction settings of the tapped pads.
- R8: When lcd_coms>=5, pad 27 is claimed: pad_seg_en=1, pad_oe=0, pad_lvl=com_lvl_a. When lcd_coms>=6, pad 26 is claimed in the same way with com_lvl_b. A claim takes priority over the mode map and over direction.
- R9: A claim does not alter any register. Lowering lcd_coms restores the pad's programmed function, and address 0 reads back the unchanged mode map throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data, one bit per pad |
| bus_rdata | output | 32 | Read data for bus_addr |
| lcd_coms | input | 3 | Number of LCD commons in use |
| seg_lvl | input | 64 | Segment level codes, 2 bits per pad |
| com_lvl_a | input | 2 | Level code for the first claimed common |
| com_lvl_b | input | 2 | Level code for the second claimed common |
| pad_di | input | 32 | Pad input levels |
| btn_di | input | 1 | Dedicated input-only pad |
| pad_oe | output | 32 | Pad output enables |
| pad_do | output | 32 | Pad output data |
| pad_seg_en | output | 32 | Pad selects the segment driver |
| pad_lvl | output | 64 | Level code per pad, 2 bits each |
| evt_out | output | 11 | Synchronized event taps |

## Verification
A corrupted mode or direction bit shows up at once on pad_oe, pad_seg_en and pad_lvl, in the same cycle the register changes. A fault in the synchronizer chain shows as an event bit or data-view bit that changes one edge early or late. The bench looks for this by stepping a pad level and sampling after each single edge. A claim that is missed or that sticks is visible on the claimed pad as soon as lcd_coms changes. A claim that corrupts storage shows only after the depth is lowered, or when the mode map is read back.

// File: rtl/spm_pkg.sv
package spm_pkg;
  // Returns 1 when pad idx is taken over as an LCD common at the given depth.
  function automatic logic is_claimed(input int idx, input int coms,
                                      input int pin_a, input int pin_b,
                                      input int depth_a, input int depth_b);
    return ((idx == pin_a) && (coms >= depth_a)) ||
           ((idx == pin_b) && (coms >= depth_b));
  endfunction

  // Data view bit of one pad: segment pads read 0, outputs read the driven value.
  function automatic logic view_bit(input logic lcd, input logic dir,
                                    input logic dout, input logic synced);
    if (lcd) return 1'b0;
    return dir ? dout : synced;
  endfunction
endpackage

// File: rtl/spm_sync.sv
module spm_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/spm_regs.sv
module spm_regs #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [1:0]   addr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mode_q,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] dout_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      dout_q <= '0;
    end else if (wr) begin
      case (addr)
        2'd0:    mode_q <= wdata;
        2'd1:    dir_q  <= wdata;
        2'd2:    dout_q <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spm_pin_cell.sv
module spm_pin_cell #(
  parameter int LVL_W = 2
) (
  input  logic             claimed,
  input  logic [LVL_W-1:0] claim_lvl,
  input  logic             mode,
  input  logic             dir,
  input  logic             dout,
  input  logic [LVL_W-1:0] seg_lvl,
  input  logic             synced,
  output logic             oe,
  output logic             dout_pad,
  output logic             seg_en,
  output logic [LVL_W-1:0] lvl,
  output logic             view
);
  logic lcd;
  always_comb begin
    lcd      = claimed | mode;
    seg_en   = lcd;
    oe       = ~lcd & dir;
    dout_pad = oe & dout;
    if (claimed)   lvl = claim_lvl;
    else if (mode) lvl = seg_lvl;
    else           lvl = '0;
    view     = spm_pkg::view_bit(lcd, dir, dout, synced);
  end
endmodule

// File: rtl/shared_pin_mux.sv
module shared_pin_mux #(
  parameter int N_PINS   = 32,
  parameter int LVL_W    = 2,
  parameter int DEPTH_W  = 3,
  parameter int EVT_BASE = 2,
  parameter int EVT_N    = 10,
  parameter int CLAIM_A  = 27,
  parameter int CLAIM_B  = 26,
  parameter int DEPTH_A  = 5,
  parameter int DEPTH_B  = 6,
  localparam int EVT_W   = EVT_N + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic [1:0]              bus_addr,
  input  logic [N_PINS-1:0]       bus_wdata,
  output logic [N_PINS-1:0]       bus_rdata,
  input  logic [DEPTH_W-1:0]      lcd_coms,
  input  logic [N_PINS*LVL_W-1:0] seg_lvl,
  input  logic [LVL_W-1:0]        com_lvl_a,
  input  logic [LVL_W-1:0]        com_lvl_b,
  input  logic [N_PINS-1:0]       pad_di,
  input  logic                    btn_di,
  output logic [N_PINS-1:0]       pad_oe,
  output logic [N_PINS-1:0]       pad_do,
  output logic [N_PINS-1:0]       pad_seg_en,
  output logic [N_PINS*LVL_W-1:0] pad_lvl,
  output logic [EVT_W-1:0]        evt_out
);
  logic [N_PINS-1:0] mode_q, dir_q, dout_q;
  logic [N_PINS-1:0] pad_sync, view_w, claim_w;
  logic              btn_sync;

  spm_regs #(.N(N_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .mode_q(mode_q), .dir_q(dir_q), .dout_q(dout_q)
  );

  spm_sync #(.W(N_PINS)) u_pad_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_di), .q(pad_sync)
  );

  spm_sync #(.W(1)) u_btn_sync (
    .clk(clk), .rst_n(rst_n), .d(btn_di), .q(btn_sync)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic [LVL_W-1:0] claim_lvl;
    assign claim_w[i] = spm_pkg::is_claimed(i, int'(lcd_coms), CLAIM_A, CLAIM_B,
                                             DEPTH_A, DEPTH_B);
    assign claim_lvl  = (i == CLAIM_A) ? com_lvl_a : com_lvl_b;
    spm_pin_cell #(.LVL_W(LVL_W)) u_cell (
      .claimed(claim_w[i]), .claim_lvl(claim_lvl), .mode(mode_q[i]),
      .dir(dir_q[i]), .dout(dout_q[i]), .seg_lvl(seg_lvl[i*LVL_W +: LVL_W]),
      .synced(pad_sync[i]), .oe(pad_oe[i]), .dout_pad(pad_do[i]),
      .seg_en(pad_seg_en[i]), .lvl(pad_lvl[i*LVL_W +: LVL_W]), .view(view_w[i])
    );
  end

  assign evt_out = {btn_sync, pad_sync[EVT_BASE +: EVT_N]};

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = mode_q;
      2'd1:    bus_rdata = dir_q;
      2'd2:    bus_rdata = view_w;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spm_checker.sv
module spm_checker #(
  parameter int N_PINS   = 32,
  parameter int EVT_BASE = 2,
  parameter int EVT_N    = 10,
  parameter int DEPTH_W  = 3,
  parameter int CLAIM_A  = 27,
  parameter int DEPTH_A  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_PINS-1:0] pad_oe,
  input logic [N_PINS-1:0] pad_do,
  input logic [N_PINS-1:0] pad_seg_en,
  input logic [N_PINS-1:0] pad_di,
  input logic              btn_di,
  input logic [DEPTH_W-1:0] lcd_coms,
  input logic [EVT_N:0]    evt_out
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r1_reset_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd0) |-> (pad_oe == '0 && pad_seg_en == '0));

  a_r2_seg_never_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_seg_en) == '0);

  a_r3_do_only_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_do & ~pad_oe) == '0);

  a_r6_event_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (evt_out == $past({btn_di, pad_di[EVT_BASE +: EVT_N]}, 2)));

  a_r8_claim_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(lcd_coms) >= DEPTH_A) |-> (pad_seg_en[CLAIM_A] && !pad_oe[CLAIM_A]));
endmodule

bind shared_pin_mux spm_checker #(
  .N_PINS(N_PINS), .EVT_BASE(EVT_BASE), .EVT_N(EVT_N), .DEPTH_W(DEPTH_W),
  .CLAIM_A(CLAIM_A), .DEPTH_A(DEPTH_A)
) u_spm_checker (
  .clk(clk), .rst_n(rst_n), .pad_oe(pad_oe), .pad_do(pad_do),
  .pad_seg_en(pad_seg_en), .pad_di(pad_di), .btn_di(btn_di),
  .lcd_coms(lcd_coms), .evt_out(evt_out)
);

// File: tb/test_shared_pin_mux.sv
`timescale 1ns/1ps
module test_shared_pin_mux;
  localparam int N = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0, bus_rdata;
  logic [2:0] lcd_coms = 3'd4;
  logic [2*N-1:0] seg_lvl = '0, pad_lvl;
  logic [1:0] com_lvl_a = 2'd1, com_lvl_b = 2'd2;
  logic [N-1:0] pad_di = '0, pad_oe, pad_do, pad_seg_en;
  logic btn_di = 1'b0;
  logic [10:0] evt_out;
  int checks = 0, fails = 0;

  // bench shadow of the programmed state
  logic [N-1:0] m_mode = '0, m_dir = '0, m_dout = '0;

  always #2.5 clk = ~clk;

  shared_pin_mux i_shared_pin_mux (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lcd_coms(lcd_coms),
    .seg_lvl(seg_lvl), .com_lvl_a(com_lvl_a), .com_lvl_b(com_lvl_b),
    .pad_di(pad_di), .btn_di(btn_di), .pad_oe(pad_oe), .pad_do(pad_do),
    .pad_seg_en(pad_seg_en), .pad_lvl(pad_lvl), .evt_out(evt_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit taken(input int i);
    return (i == 27 && lcd_coms >= 3'd5) || (i == 26 && lcd_coms >= 3'd6);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      2'd0: m_mode = d;
      2'd1: m_dir = d;
      2'd2: m_dout = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  // pad_di must have been stable for at least two edges before this call
  task automatic check_all(input string tag);
    logic [N-1:0] e_oe, e_do, e_seg, e_view, r;
    logic [2*N-1:0] e_lvl;
    for (int i = 0; i < N; i++) begin
      bit lcd = taken(i) || m_mode[i];
      e_seg[i] = lcd;
      e_oe[i]  = !lcd && m_dir[i];
      e_do[i]  = e_oe[i] && m_dout[i];
      e_view[i] = lcd ? 1'b0 : (m_dir[i] ? m_dout[i] : pad_di[i]);
      if (taken(i)) e_lvl[2*i +: 2] = (i == 27) ? com_lvl_a : com_lvl_b;
      else if (m_mode[i]) e_lvl[2*i +: 2] = seg_lvl[2*i +: 2];
      else e_lvl[2*i +: 2] = 2'b00;
    end
    chk({tag, " R2/R8 seg_en"}, 64'(pad_seg_en), 64'(e_seg));
    chk({tag, " R3 oe"}, 64'(pad_oe), 64'(e_oe));
    chk({tag, " R3 do"}, 64'(pad_do), 64'(e_do));
    chk({tag, " R2 lvl"}, pad_lvl, e_lvl);
    chk({tag, " R6 R7 evt"}, 64'(evt_out), 64'({btn_di, pad_di[11:2]}));
    rd(2'd0, r); chk({tag, " R4 R9 mode rd"}, 64'(r), 64'(m_mode));
    rd(2'd1, r); chk({tag, " R4 dir rd"}, 64'(r), 64'(m_dir));
    rd(2'd2, r); chk({tag, " R5 view"}, 64'(r), 64'(e_view));
    rd(2'd3, r); chk({tag, " R4 addr3"}, 64'(r), 64'(0));
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] r;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 oe at reset", 64'(pad_oe), 64'(0));
    chk("R1 seg_en at reset", 64'(pad_seg_en), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset");

    // R4: address 3 ignores writes
    wr(2'd3, '1);
    check_all("R4 write addr3");

    // R6 latency: step pad 5 and btn, sample after each edge
    pad_di = '0; btn_di = 1'b0; repeat (3) @(negedge clk);
    pad_di[5] = 1'b1; btn_di = 1'b1;
    @(negedge clk);
    chk("R6 one edge", 64'(evt_out), 64'(0));
    @(negedge clk);
    chk("R6 two edges", 64'(evt_out), 64'({1'b1, 10'b0000001000}));

    // R7: taps keep following pads set as outputs and segments
    wr(2'd1, 32'h0000_0FF0); wr(2'd2, 32'h0);
    wr(2'd0, 32'h0000_000C);
    pad_di = 32'h0000_0A54; repeat (3) @(negedge clk);
    check_all("R7 dir/mode mix");

    // R8/R9: claims override, then release
    wr(2'd0, 32'h0); wr(2'd1, 32'h0C00_0000); wr(2'd2, 32'h0C00_0000);
    lcd_coms = 3'd6; #1;
    check_all("R8 six commons");
    lcd_coms = 3'd5; #1;
    check_all("R8 five commons");
    lcd_coms = 3'd4; #1;
    check_all("R9 released");

    // random mix
    for (int it = 0; it < 60; it++) begin
      wr(2'd0, $urandom); wr(2'd1, $urandom); wr(2'd2, $urandom);
      lcd_coms = 3'(1 + $urandom_range(0, 5));
      seg_lvl = {$urandom, $urandom};
      com_lvl_a = 2'($urandom); com_lvl_b = 2'($urandom);
      pad_di = $urandom; btn_di = 1'($urandom);
      repeat (3) @(negedge clk);
      check_all("rand");
    end

    // reset again mid-run returns to inputs (R1)
    rst_n = 1'b0; m_mode = '0; m_dir = '0; m_dout = '0; lcd_coms = 3'd4;
    @(negedge clk);
    rst_n = 1'b1;
    pad_di = '0; btn_di = 1'b0; repeat (3) @(negedge clk);
    check_all("R1 re-reset");
    rd(2'd2, r);
    chk("R5 inputs low", 64'(r), 64'(0));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule